// File: doc/BRIEF.md
# Sequential Booth Radix-2 Multiplier

This block multiplies two 32-bit operands over many clock cycles and returns the 64-bit product split into a high word and a low word. It uses one adder/subtractor, one register for the multiplicand and one product register. The multiplier operand starts in the low half of the product register. An extra guard bit sits to the right of that half. Each clock performs one iteration, so a full product takes as many iterations as the operand has bits. A mode input picks two's-complement multiplication or unsigned multiplication. Signed mode uses Booth recoding of the low bit together with the guard bit. Unsigned mode uses plain shift-and-add, and the adder carry moves into the top of the register.

A controller with three states sequences the work. In IDLE a pulse on `start` loads the operands and moves to RUN. This is the IDLE→RUN transition. RUN stays in place for 31 iterations. On the 32nd iteration it moves to DONE (RUN→DONE) and captures the result. DONE lasts one cycle and then returns to IDLE (DONE→IDLE). `busy` is high in RUN and DONE, and `done` is high only in DONE.

Top module: `booth_seq_mul`

## Requirements
- R1: While reset is held and right after it, `busy`, `done`, `hi` and `lo` are all 0.
- R2: A `start` high at a rising edge while `busy` is low begins an operation, and `busy` is high from the next cycle.
- R3: With `mode` = 1 the result {hi,lo} equals the 64-bit two's-complement product of `op_a` and `op_b`. For example, 2×7 gives 14 and 2×(−3) gives 0xFFFFFFFF_FFFFFFFA.
- R4: Signed corner cases are exact. 0x80000000×0x80000000 gives 0x40000000_00000000, and 0x80000000×0xFFFFFFFF gives 0x00000000_80000000.
- R5: With `mode` = 0 the result equals the unsigned 64-bit product, and no carry is lost. For example, 0xFFFFFFFF×0xFFFFFFFF gives 0xFFFFFFFE_00000001.
- R6: `done` is high for exactly one cycle. That cycle begins 33 rising edges after the edge that accepted `start`, counting that edge as the first.
- R7: `start` is ignored while `busy` is high. Operands and mode presented then do not change the running result, and they produce no further `done`.
- R8: `hi` and `lo` hold their value from one `done` cycle until the next `done` cycle, whatever the inputs do.
- R9: `mode` is taken only at the accepting edge, so one operand pair gives different results in the two modes when the signed and unsigned readings differ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication when idle |
| mode | input | 1 | 1 = signed (Booth), 0 = unsigned |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| busy | output | 1 | Operation in progress (RUN or DONE) |
| done | output | 1 | One-cycle completion pulse |
| hi | output | 32 | Upper half of the last product |
| lo | output | 32 | Lower half of the last product |

## Verification
The hardest case to reach from the ports is a subtraction or addition whose intermediate result needs one bit more than the operand width. This happens when the most negative multiplicand is subtracted from an empty high half, or when an all-ones unsigned multiplicand is added to a nearly full one. The stimulus reaches these cases with the most negative value squared, the most negative value times −1, and all-ones operands in both modes. A second `start` carrying different operands and the opposite mode is injected in the middle of a run. It must leave both the result and the count of completion pulses unchanged.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mul_state_t;

    typedef enum logic [1:0] {
        OP_SKIP = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } step_op_t;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic     signed_mode,
    input  logic     lsb,
    input  logic     guard,
    output step_op_t op
);

    always_comb begin
        op = OP_SKIP;
        if (signed_mode) begin
            unique case ({lsb, guard})
                2'b10:   op = OP_SUB;
                2'b01:   op = OP_ADD;
                default: op = OP_SKIP;
            endcase
        end else if (lsb) begin
            op = OP_ADD;
        end
    end

endmodule

// File: rtl/booth_step.sv
module booth_step
    import booth_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           signed_mode,
    input  step_op_t       op,
    input  logic [W-1:0]   hi_in,
    input  logic [W-1:0]   lo_in,
    input  logic [W-1:0]   mcand,
    output logic [2*W:0]   prod_next
);

    localparam int AW = W + 1;

    logic [AW-1:0] ext_hi;
    logic [AW-1:0] ext_m;
    logic [AW-1:0] acc;

    always_comb begin
        ext_hi = {signed_mode & hi_in[W-1], hi_in};
        ext_m  = {signed_mode & mcand[W-1], mcand};
        unique case (op)
            OP_ADD:  acc = ext_hi + ext_m;
            OP_SUB:  acc = ext_hi - ext_m;
            default: acc = ext_hi;
        endcase
        prod_next = {acc, lo_in};
    end

endmodule

// File: rtl/booth_fsm.sv
module booth_fsm
    import booth_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load,
    output logic step_en,
    output logic finish
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;

    mul_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          last;

    assign last = (cnt_q == CW'(W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (step_en) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (last)  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        load    = 1'b0;
        step_en = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN: begin
                busy    = 1'b1;
                step_en = 1'b1;
                finish  = last;
            end
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
    import booth_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         mode,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);

    localparam int PW = 2 * W + 1;

    logic [PW-1:0] prod_q;
    logic [PW-1:0] prod_nx;
    logic [W-1:0]  mcand_q;
    logic          mode_q;
    logic [W-1:0]  hi_q;
    logic [W-1:0]  lo_q;
    logic          load;
    logic          step_en;
    logic          finish;
    step_op_t      op;

    booth_fsm #(.W(W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .busy    (busy),
        .done    (done),
        .load    (load),
        .step_en (step_en),
        .finish  (finish)
    );

    booth_recode u_rec (
        .signed_mode (mode_q),
        .lsb         (prod_q[1]),
        .guard       (prod_q[0]),
        .op          (op)
    );

    booth_step #(.W(W)) u_step (
        .signed_mode (mode_q),
        .op          (op),
        .hi_in       (prod_q[PW-1:W+1]),
        .lo_in       (prod_q[W:1]),
        .mcand       (mcand_q),
        .prod_next   (prod_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q  <= '0;
            mcand_q <= '0;
            mode_q  <= 1'b0;
        end else if (load) begin
            prod_q  <= {{W{1'b0}}, op_b, 1'b0};
            mcand_q <= op_a;
            mode_q  <= mode;
        end else if (step_en) begin
            prod_q  <= prod_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (finish) begin
            hi_q <= prod_nx[PW-1:W+1];
            lo_q <= prod_nx[W:1];
        end
    end

    assign hi = hi_q;
    assign lo = lo_q;

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] hi,
    input logic [W-1:0] lo
);

    localparam int CW = $clog2(W + 2) + 1;

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + CW'(1);
        end
    end

    // R2
    p_start_takes_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R6
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    p_done_latency_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == CW'(W)));

    // R7
    p_run_not_cut_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // R8
    p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({hi, lo}));

endmodule

bind booth_seq_mul booth_mul_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .hi    (hi),
    .lo    (lo)
);

// File: tb/sim_booth_seq_mul.sv
`timescale 1ns/1ps
module sim_booth_seq_mul;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [31:0] a_in = '0;
    logic [31:0] b_in = '0;
    logic        busy;
    logic        done;
    logic [31:0] hi;
    logic [31:0] lo;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic prev_done = 1'b0;
    logic [63:0] last_exp = '0;

    logic [63:0] exp_q[$];
    int          due_q[$];
    string       tag_q[$];

    booth_seq_mul u0 (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .op_a(a_in), .op_b(b_in),
        .busy(busy), .done(done), .hi(hi), .lo(lo)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                            input logic s);
        logic [63:0] ea;
        logic [63:0] eb;
        ea = s ? {{32{a[31]}}, a} : {32'b0, a};
        eb = s ? {{32{b[31]}}, b} : {32'b0, b};
        return ea * eb;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic mul_op(input logic [31:0] a, input logic [31:0] b, input logic s,
                          input string tag, input bit poke);
        @(negedge clk);
        while (busy) @(negedge clk);
        a_in  = a;
        b_in  = b;
        mode  = s;
        start = 1'b1;
        last_exp = ref_mul(a, b, s);
        exp_q.push_back(last_exp);
        due_q.push_back(cyc + 33);
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        checks++;
        if (busy !== 1'b1) begin
            fails++;
            $display("FAIL R2: busy after start got %b expected 1", busy);
        end
        if (poke) begin
            repeat (5) @(negedge clk);
            a_in  = ~a;
            b_in  = b + 32'd1;
            mode  = ~s;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R7: unexpected done got %h expected none", {hi, lo});
                end else begin
                    logic [63:0] e;
                    int          d;
                    string       t;
                    e = exp_q.pop_front();
                    d = due_q.pop_front();
                    t = tag_q.pop_front();
                    checks++;
                    if ({hi, lo} !== e) begin
                        fails++;
                        $display("FAIL %s: product got %h expected %h", t, {hi, lo}, e);
                    end
                    checks++;
                    if (cyc != d) begin
                        fails++;
                        $display("FAIL R6: done at cycle got %0d expected %0d", cyc, d);
                    end
                end
                if (prev_done) begin
                    checks++;
                    fails++;
                    $display("FAIL R6: done width got 2+ cycles expected 1");
                end
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run got hung expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (busy !== 1'b0 || done !== 1'b0 || hi !== 32'h0 || lo !== 32'h0) begin
            fails++;
            $display("FAIL R1: reset state got %b%b %h%h expected 00 0", busy, done, hi, lo);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (busy !== 1'b0 || done !== 1'b0 || hi !== 32'h0 || lo !== 32'h0) begin
            fails++;
            $display("FAIL R1: after reset got %b%b %h%h expected 00 0", busy, done, hi, lo);
        end

        // R3 small signed examples
        mul_op(32'd2, 32'd7, 1'b1, "R3", 1'b0);
        mul_op(32'd2, 32'hFFFF_FFFD, 1'b1, "R3", 1'b0);
        mul_op(32'hFFFF_FFF9, 32'd2, 1'b1, "R3", 1'b0);
        mul_op(32'd0, 32'h1234_5678, 1'b1, "R3", 1'b0);
        // R4 signed corners
        mul_op(32'h8000_0000, 32'h8000_0000, 1'b1, "R4", 1'b0);
        mul_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R4", 1'b0);
        mul_op(32'hFFFF_FFFF, 32'h8000_0000, 1'b1, "R4", 1'b0);
        mul_op(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, "R4", 1'b0);
        // R5 unsigned with carry
        mul_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R5", 1'b0);
        mul_op(32'hFFFF_FFFF, 32'd2, 1'b0, "R5", 1'b0);
        mul_op(32'h8000_0000, 32'h8000_0000, 1'b0, "R5", 1'b0);
        // R9 same operands, opposite mode
        mul_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R9", 1'b0);
        mul_op(32'hFFFF_FFFE, 32'd3, 1'b0, "R9", 1'b0);
        // R7 start during run ignored
        mul_op(32'h1357_9BDF, 32'hFEDC_BA98, 1'b1, "R7", 1'b1);
        mul_op(32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b0, "R7", 1'b1);
        // random operands in both modes
        for (int i = 0; i < 24; i++) begin
            mul_op($urandom(), $urandom(), i[0], i[0] ? "R3" : "R5", 1'b0);
        end

        @(negedge clk);
        while (busy) @(negedge clk);
        // R8 result holds while inputs move without start
        for (int k = 0; k < 40; k++) begin
            a_in = $urandom();
            b_in = $urandom();
            mode = k[0];
            @(negedge clk);
        end
        checks++;
        if ({hi, lo} !== last_exp) begin
            fails++;
            $display("FAIL R8: held result got %h expected %h", {hi, lo}, last_exp);
        end
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R7: pending results got %0d expected 0", exp_q.size());
        end
        summary();
        $finish;
    end

endmodule